// File: doc/BRIEF.md
# Multichannel Single-Slope Conversion Sequencer

This block drives the digital side of a single-slope (Wilkinson) conversion for a front-end that keeps several stored columns of analog samples. A request carries the number of columns that hold data. Column by column, the block releases an external linear ramp and runs one shared up-counter for as long as the ramp rises. Every channel watches its own comparator and freezes the counter value at the moment that comparator first trips. Because all channels share the counter, a whole column is digitised in one ramp.

When the counter reaches full scale, the block writes the codes of every channel for that column to a result memory in one word. It then holds the ramp in reset for a programmable settling time and moves on to the next column. After the last column is written it pulses a completion flag. The code width is a parameter: 12 bits by default, with 10 bits as the narrower variant.

The sequencer has five states:
- `ST_IDLE` waits for `start`.
- `ST_SETTLE` holds the ramp in reset and clears the channel latches.
- `ST_RAMP` releases the ramp and counts.
- `ST_STORE` writes one column.
- `ST_DONE` pulses completion.

Its transitions are:
- `ST_IDLE` to `ST_SETTLE` on `start` when the column count is non-zero.
- `ST_IDLE` to `ST_DONE` on `start` when the column count is zero.
- `ST_SETTLE` to `ST_RAMP` at the end of settling.
- `ST_RAMP` to `ST_STORE` when the counter is at full scale.
- `ST_STORE` to `ST_SETTLE` when more columns remain.
- `ST_STORE` to `ST_DONE` after the last column.
- `ST_DONE` to `ST_IDLE` always.

Top module: `wilk_conv_ctrl`

## Requirements
- R1: While reset is active and directly after it, `ramp_rst` is 1 and `ramp_run`, `wr_en`, `busy` and `done` are 0.
- R2: A channel whose comparator rises while `ramp_run` is high, in the k-th cycle of the ramp (first ramp cycle is k = 0), stores code k.
- R3: A channel whose comparator never rises during a ramp stores the full-scale code 2^W-1 (4095 for W = 12).
- R4: Only the first rising comparator edge of a ramp is captured; later falls and rises in the same ramp do not change the stored code.
- R5: Columns 0 to N-1 are written in ascending order on `wr_addr`, and each column is written in exactly one `wr_en` cycle.
- R6: A requested column count above 16 is clamped to 16. A count of 0 produces no write, and `done` is high in the cycle after `start`.
- R7: Before each ramp, `ramp_rst` is high (and `ramp_run` low) for exactly `settle_len` cycles, where a value of 0 counts as 1.
- R8: `ramp_run` stays high for exactly 2^W consecutive cycles per column (4096 for W = 12).
- R9: `done` is high for exactly one cycle, in the cycle that follows the write of the last column, and `busy` is low while `done` is high.
- R10: A `start` received while a conversion is in progress is ignored.
- R11: In `wr_data`, channel i occupies bits [i*W +: W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to convert the filled columns |
| col_count | input | 5 | Number of filled columns (clamped to 16) |
| settle_len | input | 8 | Settling length in cycles between ramps |
| cmp_in | input | NUM_CH | Per-channel comparator outputs |
| ramp_run | output | 1 | Ramp release, high while the shared counter runs |
| ramp_rst | output | 1 | Ramp reset, high while idle or settling |
| wr_en | output | 1 | Result write strobe |
| wr_addr | output | 4 | Column index of the result word |
| wr_data | output | NUM_CH*W | Packed channel codes of one column |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach is a comparator that trips on the very last counter value, or that never trips at all, in the same column as channels that bounce after a valid edge. In that column, saturation, a full-scale capture and ignored second edges must all be told apart in one packed word. The bench models the ramp from `ramp_run`: it counts ramp cycles and raises each comparator at a chosen cycle. The trip cycles are drawn at random, but the draws are weighted towards 0, 4094, 4095 and "never". On selected channels the comparator falls and rises again a few cycles later. A 16-column run, requested as 20 columns, also receives a stray `start` part-way through.

// File: rtl/wcc_pkg.sv
package wcc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETTLE = 3'd1,
        ST_RAMP   = 3'd2,
        ST_STORE  = 3'd3,
        ST_DONE   = 3'd4
    } wcc_state_e;
endpackage

// File: rtl/wcc_ramp_counter.sv
module wcc_ramp_counter #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    output logic [W-1:0] cnt,
    output logic         at_full
);
    localparam logic [W-1:0] FULL = {W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (run) cnt <= cnt + 1'b1;
        else          cnt <= '0;
    end

    assign at_full = run && (cnt == FULL);

    // counter is held at zero whenever the ramp is not released
    assert_cnt_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));
    // one step per ramp cycle, so cycle k carries code k
    assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !at_full) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/wcc_chan_capture.sv
module wcc_chan_capture #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         arm,
    input  logic         cmp,
    input  logic [W-1:0] cnt,
    output logic [W-1:0] result
);
    localparam logic [W-1:0] FULL = {W{1'b1}};

    logic         cmp_d;
    logic         got;
    logic [W-1:0] code_q;
    logic         hit;

    assign hit = arm && cmp && !cmp_d && !got;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_d  <= 1'b0;
            got    <= 1'b0;
            code_q <= '0;
        end else begin
            cmp_d <= cmp;
            if (clr) begin
                got    <= 1'b0;
                code_q <= '0;
            end else if (hit) begin
                got    <= 1'b1;
                code_q <= cnt;
            end
        end
    end

    assign result = got ? code_q : FULL;

    // once a code is held, further comparator activity leaves it alone
    assert_hold_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (got && !clr) |=> ($stable(code_q) && got));
    // a channel without a captured edge reports full scale
    assert_sat_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr) |=> (result == FULL));
endmodule

// File: rtl/wcc_seq_fsm.sv
module wcc_seq_fsm
    import wcc_pkg::*;
#(
    parameter int MAX_COLS = 16,
    parameter int SET_W    = 8,
    parameter int CNT_W    = $clog2(MAX_COLS + 1),
    parameter int ADDR_W   = $clog2(MAX_COLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  col_count,
    input  logic [SET_W-1:0]  settle_len,
    input  logic              at_full,
    output logic              ramp_run,
    output logic              ramp_rst,
    output logic              lat_clr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              busy,
    output logic              done
);
    wcc_state_e        state, state_nx;
    logic [CNT_W-1:0]  cols_q;
    logic [SET_W-1:0]  settle_q;
    logic [SET_W-1:0]  set_cnt;
    logic [ADDR_W-1:0] col_q;
    logic [CNT_W-1:0]  col_sat;
    logic              set_last;
    logic              col_last;

    assign col_sat  = (col_count > CNT_W'(MAX_COLS)) ? CNT_W'(MAX_COLS) : col_count;
    assign set_last = (settle_q == '0) || (set_cnt == settle_q - 1'b1);
    assign col_last = ((CNT_W'(col_q) + 1'b1) == cols_q);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = (col_sat == '0) ? ST_DONE : ST_SETTLE;
            ST_SETTLE: if (set_last) state_nx = ST_RAMP;
            ST_RAMP:   if (at_full) state_nx = ST_STORE;
            ST_STORE:  state_nx = col_last ? ST_DONE : ST_SETTLE;
            ST_DONE:   state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cols_q   <= '0;
            settle_q <= '0;
            set_cnt  <= '0;
            col_q    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    cols_q   <= col_sat;
                    settle_q <= settle_len;
                    set_cnt  <= '0;
                    col_q    <= '0;
                end
                ST_SETTLE: set_cnt <= set_cnt + 1'b1;
                ST_STORE: begin
                    set_cnt <= '0;
                    if (!col_last) col_q <= col_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        ramp_run = 1'b0;
        ramp_rst = 1'b0;
        lat_clr  = 1'b0;
        wr_en    = 1'b0;
        busy     = 1'b0;
        done     = 1'b0;
        unique case (state)
            ST_IDLE:   ramp_rst = 1'b1;
            ST_SETTLE: begin ramp_rst = 1'b1; lat_clr = 1'b1; busy = 1'b1; end
            ST_RAMP:   begin ramp_run = 1'b1; busy = 1'b1; end
            ST_STORE:  begin wr_en = 1'b1; busy = 1'b1; end
            ST_DONE:   done = 1'b1;
            default:   ramp_rst = 1'b1;
        endcase
    end

    assign wr_addr = col_q;

    assert_wr_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);
    assert_addr_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (CNT_W'(wr_addr) < cols_q));
    assert_done_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(wr_en) || $past(state == ST_IDLE)));
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_ramp_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_run |-> !ramp_rst);
    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !wr_en) |=> $stable(cols_q));
endmodule

// File: rtl/wilk_conv_ctrl.sv
module wilk_conv_ctrl #(
    parameter int NUM_CH   = 4,
    parameter int W        = 12,
    parameter int MAX_COLS = 16,
    parameter int SET_W    = 8,
    localparam int CNT_W   = $clog2(MAX_COLS + 1),
    localparam int ADDR_W  = $clog2(MAX_COLS),
    localparam int DATA_W  = NUM_CH * W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  col_count,
    input  logic [SET_W-1:0]  settle_len,
    input  logic [NUM_CH-1:0] cmp_in,
    output logic              ramp_run,
    output logic              ramp_rst,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              busy,
    output logic              done
);
    logic [W-1:0] cnt;
    logic         at_full;
    logic         lat_clr;

    wcc_seq_fsm #(
        .MAX_COLS (MAX_COLS),
        .SET_W    (SET_W),
        .CNT_W    (CNT_W),
        .ADDR_W   (ADDR_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .col_count  (col_count),
        .settle_len (settle_len),
        .at_full    (at_full),
        .ramp_run   (ramp_run),
        .ramp_rst   (ramp_rst),
        .lat_clr    (lat_clr),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .busy       (busy),
        .done       (done)
    );

    wcc_ramp_counter #(.W(W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (ramp_run),
        .cnt     (cnt),
        .at_full (at_full)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        wcc_chan_capture #(.W(W)) u_cap (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (lat_clr),
            .arm    (ramp_run),
            .cmp    (cmp_in[ch]),
            .cnt    (cnt),
            .result (wr_data[ch*W +: W])
        );
    end

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !wr_en));
    assert_write_after_ramp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(ramp_run));
endmodule

// File: tb/wilk_conv_ctrl_tb_top.sv
module wilk_conv_ctrl_tb_top;
    localparam int NCH  = 4;
    localparam int W    = 12;
    localparam int FULL = (1 << W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [4:0]       col_count = '0;
    logic [7:0]       settle_len = '0;
    logic [NCH-1:0]   cmp_in = '0;
    logic             ramp_run, ramp_rst, wr_en, busy, done;
    logic [3:0]       wr_addr;
    logic [NCH*W-1:0] wr_data;

    always #4 clk = ~clk;

    wilk_conv_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .col_count(col_count),
        .settle_len(settle_len), .cmp_in(cmp_in), .ramp_run(ramp_run),
        .ramp_rst(ramp_rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(busy), .done(done)
    );

    int n_chk = 0;
    int n_fail = 0;
    int thr [16][NCH];
    bit dbl [16][NCH];
    int exp_cols, exp_settle, wr_seen, settle_run, kcur;
    bit exp_done_nx, zero_case, done_seen, active;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic int exp_code(input int t);
        return (t > FULL) ? FULL : t;
    endfunction

    function automatic bit cmp_level(input int k, input int t, input bit d);
        if (k < t) return 1'b0;
        if (d && k >= t + 3 && k < t + 6) return 1'b0;
        return 1'b1;
    endfunction

    // ramp/comparator model and output monitor
    always @(negedge clk) begin
        if (rst_n && active) begin
            if (busy && ramp_rst) settle_run++;
            if (ramp_run) begin
                if (kcur == 0) begin
                    chk(settle_run == exp_settle, "R7 settle length", settle_run, exp_settle);
                    settle_run = 0;
                end
                for (int i = 0; i < NCH; i++)
                    cmp_in[i] <= cmp_level(kcur, thr[wr_seen % 16][i], dbl[wr_seen % 16][i]);
                kcur++;
            end else begin
                cmp_in <= '0;
            end
            if (exp_done_nx) begin
                chk(done == 1'b1, "R9 done after last write", int'(done), 1);
                chk(busy == 1'b0, "R9 busy low with done", int'(busy), 0);
                exp_done_nx = 1'b0;
                done_seen = 1'b1;
            end else if (done && !zero_case) begin
                chk(1'b0, "R9 unexpected done", 1, 0);
            end
            if (wr_en) begin
                chk(int'(wr_addr) == wr_seen, "R5 column order", int'(wr_addr), wr_seen);
                chk(kcur == FULL + 1, "R8 ramp length", kcur, FULL + 1);
                for (int i = 0; i < NCH; i++) begin
                    // R11 lane i at [i*W +: W]; R2 code k, R3 saturation, R4 first edge
                    chk(int'(wr_data[i*W +: W]) == exp_code(thr[wr_seen % 16][i]),
                        dbl[wr_seen % 16][i] ? "R4 first edge only" :
                        (thr[wr_seen % 16][i] > FULL ? "R3 saturation" : "R2 R11 channel code"),
                        int'(wr_data[i*W +: W]), exp_code(thr[wr_seen % 16][i]));
                end
                wr_seen++;
                kcur = 0;
                if (wr_seen == exp_cols) exp_done_nx = 1'b1;
            end
        end
    end

    task automatic fill(input int cols);
        for (int c = 0; c < cols; c++)
            for (int i = 0; i < NCH; i++) begin
                int r;
                r = int'($urandom % 8);
                case (r)
                    0: thr[c][i] = 0;
                    1: thr[c][i] = FULL;
                    2: thr[c][i] = FULL + 900;
                    3: thr[c][i] = FULL - 1;
                    default: thr[c][i] = int'($urandom % (FULL + 1));
                endcase
                dbl[c][i] = (($urandom % 3) == 0) && (thr[c][i] + 6 <= FULL);
            end
    endtask

    task automatic run_conv(input int cols, input int settle, input bit stray);
        exp_cols   = (cols > 16) ? 16 : cols;
        exp_settle = (settle == 0) ? 1 : settle;
        wr_seen = 0; settle_run = 0; kcur = 0;
        done_seen = 1'b0; exp_done_nx = 1'b0; zero_case = 1'b0;
        active = 1'b1;
        @(negedge clk);
        col_count = 5'(cols); settle_len = 8'(settle); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int n = 0; n < 80000 && !done_seen; n++) begin
            @(negedge clk);
            if (stray && n == 5000) begin
                col_count = 5'd1; start = 1'b1;   // R10 stray request
            end else begin
                start = 1'b0;
            end
        end
        chk(done_seen, "R9 completion seen", int'(done_seen), 1);
        chk(wr_seen == exp_cols, (cols > 16) ? "R6 R10 clamp and ignore" : "R5 write count",
            wr_seen, exp_cols);
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R9 single done cycle", int'(done), 0);
        active = 1'b0;
    endtask

    initial begin
        void'($urandom(32'h5EED_0C0D));
        active = 1'b0;
        repeat (3) @(negedge clk);
        chk(ramp_rst == 1'b1, "R1 ramp reset in reset", int'(ramp_rst), 1);
        chk({ramp_run, wr_en, busy, done} == 4'b0, "R1 outputs low in reset",
            int'({ramp_run, wr_en, busy, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ramp_rst == 1'b1 && !ramp_run && !busy, "R1 idle after reset", int'(busy), 0);

        fill(3);
        run_conv(3, 5, 1'b0);

        // R6 zero columns: done in cycle after start, no writes
        wr_seen = 0; zero_case = 1'b1; active = 1'b1; exp_done_nx = 1'b0;
        @(negedge clk);
        col_count = 5'd0; settle_len = 8'd2; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b1, "R6 zero columns done", int'(done), 1);
        chk(busy == 1'b0, "R6 zero columns not busy", int'(busy), 0);
        @(negedge clk);
        chk(done == 1'b0 && wr_seen == 0, "R6 zero columns no write", wr_seen, 0);
        active = 1'b0; zero_case = 1'b0;

        fill(16);
        run_conv(20, 0, 1'b1);

        // directed: one column, saturation, zero code, bounce
        thr[0][0] = 0;        dbl[0][0] = 1'b1;
        thr[0][1] = FULL + 1; dbl[0][1] = 1'b0;
        thr[0][2] = FULL;     dbl[0][2] = 1'b0;
        thr[0][3] = 1234;     dbl[0][3] = 1'b1;
        run_conv(1, 9, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule